// File: doc/BRIEF.md
# BIP-8 Parity Error Counter

This block watches a byte-wide frame stream and checks it against an 8-bit interleaved parity carried in-band. For each frame it XORs together every byte flagged as covered. When the next frame starts, that value becomes the reference. The byte at the parity position of the new frame is compared with the reference. Frame alignment and the choice of covered bytes are made upstream; this block only sees a frame-start marker, a coverage enable, a parity-position marker and a byte-valid strobe.

Mismatches are counted in one of two modes. In bit mode every differing parity bit adds one to the count. In block mode a frame with any difference adds exactly one. The count goes into a saturating accumulator. It is sized so that one second of worst-case bit-mode errors fits, and software reads and clears it at least once a second through a read-and-clear strobe. A one-cycle pulse flags each frame whose parity check failed.

Top module: `bip8_err_counter`

## Requirements
- R1: The reference for a frame is the XOR of all bytes of the previous frame taken while `byte_vld`=1 and `cov_en`=1, so bit i is the even parity of bit i of those bytes. A byte taken with `frame_sof`=1 is the first byte of a new frame.
- R2: In bit mode (`mode_block`=0), a parity byte (`byte_vld`=1 and `par_pos`=1) adds the number of bits that differ from the reference to the count, from 0 to 8.
- R3: In block mode (`mode_block`=1), a parity byte that differs from the reference in any bit adds exactly 1 to the count.
- R4: The count saturates at 2^CNT_W-1 and holds there while errors keep arriving. CNT_W defaults to 20, which covers 8000 frames of 8 errors each.
- R5: After reset no error is counted until a frame start has been seen twice. Parity bytes in the first frame only prime the reference.
- R6: While `rd_clr`=1, `err_count` shows the value accumulated so far. On the next clock the count becomes exactly the errors from a parity byte in that same cycle, or 0 if there is none.
- R7: `err_pulse` is high for the one cycle after a parity byte that differs from the reference, in either mode, and low after a matching parity byte.
- R8: A cycle with `byte_vld`=0 changes nothing, whatever `frame_sof`, `cov_en`, `par_pos` and `byte_in` carry. A valid byte with `cov_en`=0 is left out of the parity.
- R9: During and after reset, `err_count` is 0 and `err_pulse` is 0.
- R10: The count and `err_pulse` both change on the clock edge that takes the parity byte, so both are visible one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Stream byte |
| byte_vld | input | 1 | Byte qualifier |
| frame_sof | input | 1 | First byte of a frame |
| cov_en | input | 1 | Byte is covered by the parity |
| par_pos | input | 1 | Byte is the received parity byte |
| mode_block | input | 1 | 0 counts bits, 1 counts frames |
| rd_clr | input | 1 | Read-and-clear strobe |
| err_count | output | CNT_W | Saturating error count |
| err_pulse | output | 1 | One-cycle frame error flag |

## Verification
The parity reference is loaded at the edge that takes a frame-start byte. The count and the error pulse are both registered at the edge that takes the parity byte. The bench therefore checks them at the falling edge right after the parity beat, before it drives the next beat. A read is checked on the falling edge where the strobe is set, before its clearing edge. The cleared value is checked at the falling edge after that. A table of frames with chosen bit flips drives the main run, and the bench keeps its own running parity and expected count. Directed tests then cover priming, read-and-clear, saturation and reset.

// File: rtl/bip8_pkg.sv
package bip8_pkg;
  localparam int unsigned BIP_W = 8;
  localparam int unsigned INC_W = $clog2(BIP_W + 1);

  typedef enum logic {CNT_BITS = 1'b0, CNT_FRAMES = 1'b1} cnt_mode_e;

  // fold one byte into the running interleaved parity
  function automatic logic [BIP_W-1:0] bip_fold(input logic [BIP_W-1:0] acc,
                                                input logic [BIP_W-1:0] b);
    return acc ^ b;
  endfunction

  // number of set bits in a parity difference
  function automatic logic [INC_W-1:0] bit_weight(input logic [BIP_W-1:0] v);
    logic [INC_W-1:0] n;
    n = '0;
    for (int i = 0; i < int'(BIP_W); i++) n = n + INC_W'(v[i]);
    return n;
  endfunction

  // errors a single parity byte contributes under the selected mode
  function automatic logic [INC_W-1:0] err_weight(input logic [BIP_W-1:0] diff,
                                                  input cnt_mode_e m);
    if (m == CNT_FRAMES) return INC_W'(|diff);
    return bit_weight(diff);
  endfunction
endpackage

// File: rtl/bip8_accum.sv
module bip8_accum
  import bip8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BIP_W-1:0] byte_in,
  input  logic             byte_vld,
  input  logic             frame_sof,
  input  logic             cov_en,
  output logic [BIP_W-1:0] ref_par,
  output logic             ref_valid
);
  logic [BIP_W-1:0] acc_q;
  logic             seen_q;
  logic             take_w;
  logic             sof_w;
  logic [BIP_W-1:0] seed_w;

  assign take_w = byte_vld && cov_en;
  assign sof_w  = byte_vld && frame_sof;
  assign seed_w = take_w ? byte_in : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ref_par   <= '0;
      seen_q    <= 1'b0;
      ref_valid <= 1'b0;
    end else if (sof_w) begin
      ref_par   <= acc_q;
      ref_valid <= seen_q;
      seen_q    <= 1'b1;
      acc_q     <= seed_w;
    end else if (take_w) begin
      acc_q <= bip_fold(acc_q, byte_in);
    end
  end
endmodule

// File: rtl/bip8_compare.sv
module bip8_compare
  import bip8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BIP_W-1:0] byte_in,
  input  logic             byte_vld,
  input  logic             par_pos,
  input  logic             mode_block,
  input  logic [BIP_W-1:0] ref_par,
  input  logic             ref_valid,
  output logic [INC_W-1:0] err_inc,
  output logic             err_pulse
);
  logic             chk_w;
  logic [BIP_W-1:0] diff_w;
  cnt_mode_e        mode_w;

  assign chk_w  = byte_vld && par_pos && ref_valid;
  assign diff_w = chk_w ? (byte_in ^ ref_par) : '0;
  assign mode_w = cnt_mode_e'(mode_block);

  always_comb err_inc = err_weight(diff_w, mode_w);

  always_ff @(posedge clk) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= |diff_w;
  end
endmodule

// File: rtl/bip8_sat_counter.sv
module bip8_sat_counter
  import bip8_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] err_inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W:0] CAP = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0]   base_w;
  logic [CNT_W:0]   sum_w;
  logic [CNT_W-1:0] next_w;

  assign base_w = rd_clr ? '0 : {1'b0, count};
  assign sum_w  = base_w + (CNT_W+1)'(err_inc);
  assign next_w = (sum_w > CAP) ? CAP[CNT_W-1:0] : sum_w[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_w;
  end
endmodule

// File: rtl/bip8_err_counter.sv
module bip8_err_counter
  import bip8_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_in,
  input  logic             byte_vld,
  input  logic             frame_sof,
  input  logic             cov_en,
  input  logic             par_pos,
  input  logic             mode_block,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] err_count,
  output logic             err_pulse
);
  logic [BIP_W-1:0] ref_par_w;
  logic             ref_valid_w;
  logic [INC_W-1:0] inc_w;

  bip8_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_in  (byte_in),
    .byte_vld (byte_vld),
    .frame_sof(frame_sof),
    .cov_en   (cov_en),
    .ref_par  (ref_par_w),
    .ref_valid(ref_valid_w)
  );

  bip8_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_in   (byte_in),
    .byte_vld  (byte_vld),
    .par_pos   (par_pos),
    .mode_block(mode_block),
    .ref_par   (ref_par_w),
    .ref_valid (ref_valid_w),
    .err_inc   (inc_w),
    .err_pulse (err_pulse)
  );

  bip8_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_inc(inc_w),
    .rd_clr (rd_clr),
    .count  (err_count)
  );
endmodule

// File: rtl/bip8_err_chk.sv
module bip8_err_chk
  import bip8_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_block,
  input logic             rd_clr,
  input logic             ref_valid,
  input logic [INC_W-1:0] inc,
  input logic [CNT_W-1:0] count,
  input logic             pulse
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_inc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc <= INC_W'(BIP_W));

  p_block_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_block |-> inc <= INC_W'(1));

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !rd_clr) |=> count == TOP);

  p_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> count >= $past(count));

  p_prime_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |-> inc == '0);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> count == CNT_W'($past(inc)));

  p_pulse_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && count != TOP && inc != '0) |=> (pulse && count != $past(count)));
endmodule

bind bip8_err_counter bip8_err_chk #(.CNT_W(CNT_W)) u_err_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_block(mode_block),
  .rd_clr    (rd_clr),
  .ref_valid (ref_valid_w),
  .inc       (inc_w),
  .count     (err_count),
  .pulse     (err_pulse)
);

// File: tb/test_bip8_err_counter.sv
`timescale 1ns/1ps
module test_bip8_err_counter;
  localparam int unsigned CW = 8;
  localparam int unsigned CMAX = (1 << CW) - 1;
  localparam int NV = 8;
  // {mode, flip, d3, d2, d1, d0}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44},
    {1'b0, 8'h01, 8'hA0, 8'h0B, 8'hC0, 8'h0D},
    {1'b0, 8'hFF, 8'h5A, 8'h5A, 8'h00, 8'hFF},
    {1'b0, 8'h00, 8'h80, 8'h40, 8'h20, 8'h10},
    {1'b1, 8'h81, 8'h12, 8'h34, 8'h56, 8'h78},
    {1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01},
    {1'b1, 8'h00, 8'hEE, 8'hDD, 8'hCC, 8'hBB},
    {1'b0, 8'h3C, 8'h9A, 8'h7B, 8'h6C, 8'h5D}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] byte_in = '0;
  logic byte_vld = 1'b0, frame_sof = 1'b0, cov_en = 1'b0, par_pos = 1'b0;
  logic mode_block = 1'b0, rd_clr = 1'b0;
  logic [CW-1:0] err_count;
  logic err_pulse;

  int n_run = 0, n_fail = 0;
  int exp_cnt = 0;
  logic [7:0] prev_par = '0;
  bit have_prev = 0;

  bip8_err_counter #(.CNT_W(CW)) i_bip8_err_counter (
    .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
    .frame_sof(frame_sof), .cov_en(cov_en), .par_pos(par_pos),
    .mode_block(mode_block), .rd_clr(rd_clr),
    .err_count(err_count), .err_pulse(err_pulse)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic fs, input logic cv,
                      input logic pp, input logic rc, input logic [7:0] d);
    byte_vld = v; frame_sof = fs; cov_en = cv; par_pos = pp; rd_clr = rc; byte_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pop8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  // one frame; the parity byte carries the previous frame's parity XOR flip
  task automatic run_frame(input logic [7:0] d0, d1, d2, d3, flip,
                           input logic mb, input logic rd);
    int inc;
    beat(1, 1, 1, 0, 0, d0);
    beat(0, 1, 1, 1, 0, 8'hA5);        // R8: invalid beat with markers set
    check("R7 pulse single cycle", err_pulse, 0);
    beat(1, 0, 1, 0, 0, d1);
    beat(1, 0, 0, 0, 0, 8'h3C);        // R8: valid but uncovered
    beat(1, 0, 1, 0, 0, d2);
    beat(1, 0, 1, 0, 0, d3);
    inc = !have_prev ? 0 : (mb ? (flip != 0 ? 1 : 0) : pop8(flip));
    mode_block = mb;
    if (rd) begin
      rd_clr = 1'b1;
      #0.5;
      check("R6 read value", int'(err_count), exp_cnt);
    end
    beat(1, 0, 0, 1, rd, prev_par ^ flip);
    exp_cnt = rd ? inc : ((exp_cnt + inc > CMAX) ? CMAX : exp_cnt + inc);
    check(mb ? "R3 R10 block count" : "R1 R2 R10 bit count", int'(err_count), exp_cnt);
    check("R7 pulse", err_pulse, (inc != 0) ? 1 : 0);
    rd_clr = 1'b0;
    prev_par = d0 ^ d1 ^ d2 ^ d3;
    have_prev = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset count", int'(err_count), 0);
    check("R9 reset pulse", err_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: first frame primes only, even with a flipped parity byte
    run_frame(8'h01, 8'h02, 8'h04, 8'h08, 8'hFF, 1'b0, 1'b0);
    check("R5 priming", int'(err_count), 0);

    for (int k = 0; k < NV; k++)
      run_frame(VEC[k][7:0], VEC[k][15:8], VEC[k][23:16], VEC[k][31:24],
                VEC[k][39:32], VEC[k][40], 1'b0);

    // R8: idle invalid beats leave the count untouched
    beat(0, 1, 1, 1, 0, 8'hFF);
    beat(0, 0, 1, 1, 0, 8'h00);
    check("R8 idle ignored", int'(err_count), exp_cnt);

    // R6: clear alone
    rd_clr = 1'b1;
    #0.5;
    check("R6 read before clear", int'(err_count), exp_cnt);
    beat(0, 0, 0, 0, 1, 8'h00);
    rd_clr = 1'b0;
    exp_cnt = 0;
    check("R6 cleared", int'(err_count), 0);

    // R6: clear coinciding with a 3-bit error
    run_frame(8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 1'b0, 1'b0);
    run_frame(8'h55, 8'h66, 8'h77, 8'h88, 8'h07, 1'b0, 1'b0);
    run_frame(8'h01, 8'h01, 8'h01, 8'h01, 8'h0B, 1'b0, 1'b1);
    check("R6 clear plus error", int'(err_count), 3);

    // R4: saturation in bit mode
    for (int k = 0; k < 34; k++)
      run_frame(8'(k), 8'(k * 3), 8'hC3, 8'h5E, 8'hFF, 1'b0, 1'b0);
    check("R4 saturated", int'(err_count), CMAX);
    run_frame(8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 1'b0);
    check("R4 holds", int'(err_count), CMAX);

    // R9 and R5 again: reset mid-run then a flipped first frame
    rst_n = 1'b0;
    beat(0, 0, 0, 0, 0, 8'h00);
    check("R9 reset mid-run count", int'(err_count), 0);
    check("R9 reset mid-run pulse", err_pulse, 0);
    rst_n = 1'b1;
    exp_cnt = 0; have_prev = 0; prev_par = '0;
    run_frame(8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h0F, 1'b0, 1'b0);
    run_frame(8'h01, 8'h02, 8'h03, 8'h04, 8'h01, 1'b1, 1'b0);
    check("R5 R3 after reset", int'(err_count), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule